// File: doc/BRIEF.md
# Row Overhead Timing Generator

This block times the overhead interval that an image sensor readout sequencer places in front of every row. It runs on the master clock and counts in sensor clocks of four master clocks each. A start-of-row request opens an overhead period. During that period a row-overhead-active output is high, and a column precharge pulse is raised at the beginning of the period. The period closes with a one-cycle done strobe.

Two byte-wide registers are loaded through simple write strobes. The control byte selects between a fixed long overhead and a short overhead set by the timer byte. It also sets the precharge width and drives three static indications: power-down, sequencer hold and dual-slope enable. A held or powered-down sequencer aborts any running period and refuses new requests.

Top module: `rowovh_gen`

## Requirements
- R1: After reset the block is idle: `ovh_active`, `prech` and `ovh_done` are low, `seq_hold` is high, and `pwr_down` and `dual_slope` are low. The control register resets to 0x00 and the timer register resets to 0x07.
- R2: Control bit 0 drives `pwr_down`, bit 3 drives `dual_slope`, and bit 1 at 0 drives `seq_hold` high. Each output shows the new value from the first clock edge that samples `ctrl_wr`.
- R3: With control bit 2 at 0 (long mode), `ovh_active` stays high for 140 master cycles, whatever the timer value.
- R4: With control bit 2 at 1 (reduced mode), `ovh_active` stays high for (N+2)*4 master cycles. N is timer bits 4:0, and timer bits 7:5 have no effect.
- R5: Control bits 5:4 set how long `prech` stays high, measured from the first active cycle: 00 gives 4 master cycles, 01 gives 8, and 10 or 11 give 12. The width leaves the period length unchanged.
- R6: `prech` is never high outside the period. With N=0 and width code 11, `prech` and `ovh_active` both last 8 cycles.
- R7: `ovh_done` is high for exactly one cycle. That cycle is the first cycle after `ovh_active` falls at the end of a period.
- R8: `ovh_active` rises on the first edge that samples `row_req` while the block is idle. A request sampled while a period runs, including in its last cycle, does not extend the period and does not start a new one.
- R9: While `seq_hold` or `pwr_down` is high, a running period is cut off within one cycle with no done strobe, and requests are ignored. After the block is re-enabled, the next period has its full length.
- R10: Mode, timer and width are captured when a period starts. A timer write during a period takes effect only from the next period.
- R11: With the reset timer value and reduced mode, a period lasts 36 master cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_wr | input | 1 | Load strobe for the control register |
| ctrl_din | input | 8 | Control byte: bit0 power-down, bit1 run, bit2 reduced mode, bit3 dual slope, bits5:4 precharge width |
| timer_wr | input | 1 | Load strobe for the timer register |
| timer_din | input | 8 | Timer byte; bits 4:0 give N |
| row_req | input | 1 | Start-of-row request |
| ovh_active | output | 1 | High during the overhead period |
| prech | output | 1 | Column precharge pulse |
| ovh_done | output | 1 | One-cycle strobe after the period ends |
| pwr_down | output | 1 | Image core power-down indication |
| seq_hold | output | 1 | Sequencer held in reset |
| dual_slope | output | 1 | Dual-slope operation enable |

## Verification
Periods are run with several timer values in both modes. Long mode with a full timer shows that the timer is ignored. The values 0, 3, 10 and 31 show that the short length follows N+2. A timer byte with its upper bits set shows that those bits are dropped. All four width codes are run against one fixed period, which separates the pulse width from the period length. The N=0, widest-pulse case shows that the pulse is clipped by the period. Requests in the middle and in the last cycle of a period, and timer writes during a period, show the difference between sampling at the start and following the registers live.

// File: rtl/rowovh_pkg.sv
package rowovh_pkg;

   localparam int REG_W = 8;

   // control fields, LSB first: pwr_dn=0, seq_run=1, reduced=2, dual=3, pre_sel=5:4
   typedef struct packed {
      logic [1:0] pre_sel;
      logic       dual;
      logic       reduced;
      logic       seq_run;
      logic       pwr_dn;
   } ctrl_t;

   localparam int CTRL_FW = $bits(ctrl_t);

endpackage

// File: rtl/rowovh_regs.sv
module rowovh_regs
   import rowovh_pkg::*;
#(
   parameter int TIMER_W = 5,
   parameter logic [TIMER_W-1:0] TIMER_RST = 5'b00111
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ctrl_wr,
   input  logic [REG_W-1:0]   ctrl_din,
   input  logic               timer_wr,
   input  logic [REG_W-1:0]   timer_din,
   output ctrl_t              ctrl_q,
   output logic [TIMER_W-1:0] timer_q
);

   if (TIMER_W < 1 || TIMER_W >= REG_W) begin : g_bad_timer_w
      $error("rowovh_regs: TIMER_W must lie in 1..REG_W-1");
   end

   logic unused_ctrl_hi;
   logic unused_timer_hi;
   assign unused_ctrl_hi  = ^ctrl_din[REG_W-1:CTRL_FW];
   assign unused_timer_hi = ^timer_din[REG_W-1:TIMER_W];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
      end else if (ctrl_wr) begin
         ctrl_q <= ctrl_t'(ctrl_din[CTRL_FW-1:0]);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         timer_q <= TIMER_RST;
      end else if (timer_wr) begin
         timer_q <= timer_din[TIMER_W-1:0];
      end
   end

endmodule

// File: rtl/rowovh_tick.sv
module rowovh_tick #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic adv,
   output logic tick
);

   if (DIV < 1) begin : g_bad_div
      $error("rowovh_tick: DIV must be at least 1");
   end

   if (DIV == 1) begin : g_pass
      assign tick = adv & ~clr;
   end else begin : g_div
      localparam int SUB_W = $clog2(DIV);
      localparam logic [SUB_W-1:0] SUB_LAST = SUB_W'(DIV - 1);

      logic [SUB_W-1:0] sub_q;

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sub_q <= '0;
         end else if (clr) begin
            sub_q <= '0;
         end else if (adv) begin
            sub_q <= (sub_q == SUB_LAST) ? '0 : sub_q + 1'b1;
         end
      end

      assign tick = adv & ~clr & (sub_q == SUB_LAST);

      // R3
      tick_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
         tick |=> !tick)
         else $error("sensor tick repeated on consecutive master cycles");
   end

endmodule

// File: rtl/rowovh_seq.sv
module rowovh_seq
   import rowovh_pkg::*;
#(
   parameter int TIMER_W  = 5,
   parameter int LONG_LEN = 35,
   parameter int LEN_OFS  = 2,
   parameter int PRE_MAX  = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               row_req,
   input  logic               blocked,
   input  logic               tick,
   input  ctrl_t              cfg,
   input  logic [TIMER_W-1:0] timer,
   output logic               tick_clr,
   output logic               active,
   output logic               prech,
   output logic               done
);

   localparam int SHORT_MAX = (1 << TIMER_W) - 1 + LEN_OFS;
   localparam int LEN_MAX   = (LONG_LEN > SHORT_MAX) ? LONG_LEN : SHORT_MAX;
   localparam int CNT_W     = $clog2(LEN_MAX + 1);
   localparam int W_W       = $clog2(PRE_MAX + 1);

   if (LONG_LEN < 1 || LEN_OFS < 1) begin : g_bad_len
      $error("rowovh_seq: period lengths must be positive");
   end
   if (PRE_MAX < 1 || W_W >= CNT_W) begin : g_bad_pre
      $error("rowovh_seq: PRE_MAX out of range");
   end

   logic             act_q;
   logic [CNT_W-1:0] scnt_q;
   logic [CNT_W-1:0] len_q;
   logic [W_W-1:0]   wid_q;
   logic             done_q;

   logic [CNT_W-1:0] len_nxt;
   logic [W_W:0]     wid_raw;
   logic [W_W-1:0]   wid_nxt;
   logic             start_ok;
   logic             last;

   always_comb begin
      len_nxt = cfg.reduced ? (CNT_W'(timer) + CNT_W'(LEN_OFS)) : CNT_W'(LONG_LEN);
      wid_raw = (W_W+1)'(cfg.pre_sel) + 1'b1;
      wid_nxt = (wid_raw > (W_W+1)'(PRE_MAX)) ? W_W'(PRE_MAX) : wid_raw[W_W-1:0];
   end

   assign start_ok = row_req & ~act_q & ~blocked;
   assign last     = act_q & tick & (scnt_q == len_q - 1'b1);
   assign tick_clr = ~act_q | blocked;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         scnt_q <= '0;
         len_q  <= '0;
         wid_q  <= '0;
      end else if (blocked) begin
         act_q  <= 1'b0;
         scnt_q <= '0;
      end else if (start_ok) begin
         act_q  <= 1'b1;
         scnt_q <= '0;
         len_q  <= len_nxt;
         wid_q  <= wid_nxt;
      end else if (act_q && tick) begin
         if (last) begin
            act_q  <= 1'b0;
            scnt_q <= '0;
         end else begin
            scnt_q <= scnt_q + 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q <= 1'b0;
      end else begin
         done_q <= last & ~blocked;
      end
   end

   assign active = act_q;
   assign prech  = act_q & (scnt_q < {{(CNT_W-W_W){1'b0}}, wid_q});
   assign done   = done_q;

   // R7
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done)
      else $error("done strobe wider than one cycle");

   // R7
   done_after_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!active && $past(active)))
      else $error("done strobe not right after the period");

   // R6
   prech_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
      prech |-> active)
      else $error("precharge outside the period");

   // R5
   prech_at_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(active) |-> prech)
      else $error("precharge missing at period start");

   // R9
   blocked_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(blocked) |-> (!active && !done))
      else $error("period ran while blocked");

   // R4
   count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      active |-> (scnt_q < len_q))
      else $error("sensor count beyond period length");

endmodule

// File: rtl/rowovh_gen.sv
module rowovh_gen
   import rowovh_pkg::*;
#(
   parameter int TIMER_W  = 5,
   parameter int TICK_DIV = 4,
   parameter int LONG_LEN = 35,
   parameter int LEN_OFS  = 2,
   parameter int PRE_MAX  = 3,
   parameter logic [TIMER_W-1:0] TIMER_RST = 5'b00111
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ctrl_wr,
   input  logic [REG_W-1:0] ctrl_din,
   input  logic             timer_wr,
   input  logic [REG_W-1:0] timer_din,
   input  logic             row_req,
   output logic             ovh_active,
   output logic             prech,
   output logic             ovh_done,
   output logic             pwr_down,
   output logic             seq_hold,
   output logic             dual_slope
);

   ctrl_t              ctrl_q;
   logic [TIMER_W-1:0] timer_q;
   logic               blocked;
   logic               tick;
   logic               tick_clr;
   logic               act;

   rowovh_regs #(
      .TIMER_W   (TIMER_W),
      .TIMER_RST (TIMER_RST)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ctrl_wr   (ctrl_wr),
      .ctrl_din  (ctrl_din),
      .timer_wr  (timer_wr),
      .timer_din (timer_din),
      .ctrl_q    (ctrl_q),
      .timer_q   (timer_q)
   );

   assign blocked = ~ctrl_q.seq_run | ctrl_q.pwr_dn;

   rowovh_tick #(
      .DIV (TICK_DIV)
   ) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (tick_clr),
      .adv   (act),
      .tick  (tick)
   );

   rowovh_seq #(
      .TIMER_W  (TIMER_W),
      .LONG_LEN (LONG_LEN),
      .LEN_OFS  (LEN_OFS),
      .PRE_MAX  (PRE_MAX)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .row_req  (row_req),
      .blocked  (blocked),
      .tick     (tick),
      .cfg      (ctrl_q),
      .timer    (timer_q),
      .tick_clr (tick_clr),
      .active   (act),
      .prech    (prech),
      .done     (ovh_done)
   );

   assign ovh_active = act;
   assign pwr_down   = ctrl_q.pwr_dn;
   assign seq_hold   = ~ctrl_q.seq_run;
   assign dual_slope = ctrl_q.dual;

   // R2
   hold_follows_reg_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(ctrl_wr) |-> (seq_hold == !$past(ctrl_din[1])))
      else $error("sequencer hold does not follow the control write");

endmodule

// File: tb/rowovh_gen_test.sv
module rowovh_gen_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       ctrl_wr = 1'b0;
   logic [7:0] ctrl_din = '0;
   logic       timer_wr = 1'b0;
   logic [7:0] timer_din = '0;
   logic       row_req = 1'b0;
   logic       ovh_active, prech, ovh_done, pwr_down, seq_hold, dual_slope;

   int errors = 0;
   int checks = 0;
   bit finished = 0;

   always #5 clk = ~clk;

   rowovh_gen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .ctrl_wr    (ctrl_wr),
      .ctrl_din   (ctrl_din),
      .timer_wr   (timer_wr),
      .timer_din  (timer_din),
      .row_req    (row_req),
      .ovh_active (ovh_active),
      .prech      (prech),
      .ovh_done   (ovh_done),
      .pwr_down   (pwr_down),
      .seq_hold   (seq_hold),
      .dual_slope (dual_slope)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // bit1 run, bit2 reduced, bit3 dual, bits5:4 width, bit0 power-down; bits 7:6 set on purpose
   function automatic logic [7:0] mk(bit run, bit red, bit dual, logic [1:0] pw, bit pd);
      return {2'b11, pw, dual, red, run, pd};
   endfunction

   task automatic wr_ctrl(input logic [7:0] v);
      ctrl_wr = 1'b1; ctrl_din = v;
      @(negedge clk);
      ctrl_wr = 1'b0;
   endtask

   task automatic wr_timer(input logic [7:0] v);
      timer_wr = 1'b1; timer_din = v;
      @(negedge clk);
      timer_wr = 1'b0;
   endtask

   task automatic run_period(input int req_at, input int wr_at, input logic [7:0] wr_val,
                             output int act_n, output int pre_n,
                             output int start_ok, output int done_ok);
      row_req = 1'b1;
      @(negedge clk);
      row_req = 1'b0;
      start_ok = int'(ovh_active && prech);
      act_n = 0; pre_n = 0;
      while (ovh_active && act_n < 400) begin
         act_n++;
         if (prech) pre_n++;
         if (act_n == req_at) row_req = 1'b1;
         if (act_n == wr_at) begin timer_wr = 1'b1; timer_din = wr_val; end
         @(negedge clk);
         row_req = 1'b0;
         timer_wr = 1'b0;
      end
      done_ok = int'(ovh_done);
      @(negedge clk);
      done_ok = int'(done_ok == 1 && !ovh_done && !ovh_active);
   endtask

   task automatic t_reset();
      check("R1 active", int'(ovh_active), 0);
      check("R1 prech", int'(prech), 0);
      check("R1 done", int'(ovh_done), 0);
      check("R1 seq_hold", int'(seq_hold), 1);
      check("R1 pwr_down", int'(pwr_down), 0);
      check("R1 dual_slope", int'(dual_slope), 0);
      row_req = 1'b1;
      repeat (3) @(negedge clk);
      row_req = 1'b0;
      check("R9 req while held after reset", int'(ovh_active), 0);
   endtask

   task automatic t_default_timer();
      int a, p, s, d;
      wr_ctrl(mk(1, 1, 0, 2'b00, 0));
      run_period(0, 0, 8'h00, a, p, s, d);
      check("R11 default timer length", a, 36);
      check("R11 default prech", p, 4);
      check("R8 start cycle", s, 1);
      check("R7 done strobe", d, 1);
   endtask

   task automatic t_ctrl_bits();
      wr_ctrl(mk(0, 0, 1, 2'b00, 1));
      check("R2 pwr_down set", int'(pwr_down), 1);
      check("R2 seq_hold set", int'(seq_hold), 1);
      check("R2 dual_slope set", int'(dual_slope), 1);
      wr_ctrl(mk(1, 0, 0, 2'b00, 0));
      check("R2 pwr_down clear", int'(pwr_down), 0);
      check("R2 seq_hold clear", int'(seq_hold), 0);
      check("R2 dual_slope clear", int'(dual_slope), 0);
   endtask

   task automatic t_long();
      int a, p, s, d;
      wr_timer(8'hFF);
      wr_ctrl(mk(1, 0, 0, 2'b00, 0));
      run_period(0, 0, 8'h00, a, p, s, d);
      check("R3 long length, timer full", a, 140);
      check("R5 long prech w0", p, 4);
      check("R7 long done", d, 1);
      wr_timer(8'h03);
      wr_ctrl(mk(1, 0, 0, 2'b10, 0));
      run_period(0, 0, 8'h00, a, p, s, d);
      check("R3 long length, timer 3", a, 140);
      check("R5 long prech w2", p, 12);
   endtask

   task automatic t_reduced();
      int a, p, s, d;
      wr_ctrl(mk(1, 1, 0, 2'b00, 0));
      wr_timer(8'hE3);
      run_period(0, 0, 8'h00, a, p, s, d);
      check("R4 upper timer bits ignored", a, 20);
      wr_timer(8'h1F);
      run_period(0, 0, 8'h00, a, p, s, d);
      check("R4 max timer", a, 132);
   endtask

   task automatic t_widths();
      int a, p, s, d;
      int exp_p[4] = '{4, 8, 12, 12};
      wr_timer(8'd10);
      for (int w = 0; w < 4; w++) begin
         wr_ctrl(mk(1, 1, 0, 2'(w), 0));
         run_period(0, 0, 8'h00, a, p, s, d);
         check($sformatf("R5 width code %0d prech", w), p, exp_p[w]);
         check($sformatf("R5 width code %0d length", w), a, 48);
      end
   endtask

   task automatic t_cap();
      int a, p, s, d;
      wr_timer(8'd0);
      wr_ctrl(mk(1, 1, 0, 2'b11, 0));
      run_period(0, 0, 8'h00, a, p, s, d);
      check("R6 short period length", a, 8);
      check("R6 prech clipped", p, 8);
      wr_ctrl(mk(1, 1, 0, 2'b00, 0));
      run_period(0, 0, 8'h00, a, p, s, d);
      check("R4 N=0 length", a, 8);
   endtask

   task automatic t_ignore();
      int a, p, s, d;
      wr_timer(8'd5);
      run_period(10, 0, 8'h00, a, p, s, d);
      check("R8 mid request ignored", a, 28);
      check("R8 no restart after mid request", d, 1);
      run_period(28, 0, 8'h00, a, p, s, d);
      check("R8 last-cycle request ignored", a, 28);
      check("R8 no restart after last-cycle request", d, 1);
   endtask

   task automatic t_sample();
      int a, p, s, d;
      wr_timer(8'd5);
      run_period(0, 3, 8'd20, a, p, s, d);
      check("R10 current period unchanged", a, 28);
      run_period(0, 0, 8'h00, a, p, s, d);
      check("R10 next period uses new timer", a, 88);
   endtask

   task automatic t_block_one(input logic [7:0] blk, input string tag);
      int a, p, s, d;
      int seen_act = 0;
      int seen_done = 0;
      wr_timer(8'd10);
      wr_ctrl(mk(1, 1, 0, 2'b01, 0));
      row_req = 1'b1;
      @(negedge clk);
      row_req = 1'b0;
      repeat (5) @(negedge clk);
      wr_ctrl(blk);
      @(negedge clk);
      check({"R9 abort active ", tag}, int'(ovh_active), 0);
      check({"R9 abort prech ", tag}, int'(prech), 0);
      for (int i = 0; i < 60; i++) begin
         row_req = (i % 7 == 0);
         @(negedge clk);
         if (ovh_active) seen_act++;
         if (ovh_done) seen_done++;
      end
      row_req = 1'b0;
      check({"R9 no activity while blocked ", tag}, seen_act, 0);
      check({"R9 no done while blocked ", tag}, seen_done, 0);
      wr_ctrl(mk(1, 1, 0, 2'b01, 0));
      run_period(0, 0, 8'h00, a, p, s, d);
      check({"R9 full period after release ", tag}, a, 48);
      check({"R9 prech after release ", tag}, p, 8);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_default_timer();
      t_ctrl_bits();
      t_long();
      t_reduced();
      t_widths();
      t_cap();
      t_ignore();
      t_sample();
      t_block_one(mk(0, 1, 0, 2'b01, 0), "hold");
      t_block_one(mk(1, 1, 0, 2'b01, 1), "power-down");
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      #(1_000_000);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule